// File: doc/BRIEF.md
# Multi-Bank Round-Robin Memory Arbiter

This block lets eight hardware tasks share four external memory banks. Every task has its own point-to-point link to the arbiter, so the tasks form a star around it rather than sharing a bus. Each link carries a request line, a two-bit command, a local address and write data. The arbiter answers on the same link with a grant, error pulses, read data and a read-valid strobe. Two tasks are tied to each bank. Each bank has its own round-robin arbiter and its own memory port, so tasks on different banks never contend with each other.

Memory is split statically. Each bank is divided into fixed blocks of `BLOCK_WORDS` words, and each task owns exactly one block. A task issues local addresses. The arbiter rejects any local address that lies outside the block. It relocates a valid address into the bank by adding the block base. A stream command keeps the bank and reads consecutive words. Separately, each bank has a host-ownership handshake. While the host holds a bank, the fabric is kept off that bank's memory port.

Top module: `mba_mem_arbiter`

## Requirements
- R1: Task t (counting from 0) is served only by bank t/2, in slot s = t%2. A valid access drives that bank's `memAddr` with s*BLOCK_WORDS + local address, where BLOCK_WORDS defaults to 200.
- R2: The command encoding is 00 idle, 01 read, 10 write and 11 stream. A grant appears in the cycle after the request is accepted, and the bank port is driven in that same cycle, with `memWe` high only for a write. Read data returns with a one-cycle `taskRvalid` exactly two cycles after the grant cycle.
- R3: Within a bank, arbitration is round-robin. The pointer moves past the served task only when its transaction completes. After reset, slot 0 has priority. Two tasks that request continuously are granted alternately.
- R4: Banks are arbitrated independently. Tasks on different banks that request in the same cycle are all granted in the same cycle.
- R5: A non-idle request whose local address is BLOCK_WORDS or higher gets a one-cycle `taskErr` pulse in the cycle after the request appears. It is never granted, and it causes no access on the bank port.
- R6: A stream holds the grant. It issues a read at the next consecutive address on every cycle that the task keeps its request high. It ends, releasing the grant, one cycle after the request drops.
- R7: A stream that would step past the last word of its block stops without making that access. It drops the grant and pulses `taskErr` for the streaming task.
- R8: When `hostReq` is high while the bank is idle, `hostOwn` rises in the next cycle, and the host wins over pending task requests. While `hostOwn` is high, the bank gives no grant and drives no access. `hostOwn` falls one cycle after `hostReq` drops, and task arbitration resumes in the cycle after that.
- R9: During reset, all grants, read-valid strobes, error pulses, host-ownership flags and memory enables are low.
- R10: At most one task per bank holds a grant in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| taskReq | input | 8 | Request line per task |
| taskCmd | input | 16 | Two-bit command per task |
| taskAddr | input | 64 | Eight-bit local address per task |
| taskWdata | input | 128 | Sixteen-bit write data per task |
| taskGnt | output | 8 | Grant per task |
| taskRvalid | output | 8 | Read data valid per task |
| taskRdata | output | 128 | Read data per task |
| taskErr | output | 8 | Address error pulse per task |
| hostReq | input | 4 | Host request per bank |
| hostOwn | output | 4 | Host owns the bank |
| memEn | output | 4 | Access enable per bank |
| memWe | output | 4 | Write enable per bank |
| memAddr | output | 36 | Nine-bit global address per bank |
| memWdata | output | 64 | Write data per bank |
| memRdata | input | 64 | Read data per bank, one cycle after the access |

## Verification
The bench probes the timing edges where arbiters usually slip:
- Read data sampled one cycle early or late would fail the exact two-cycle check.
- A pointer that moved at grant time instead of at completion would hand the bank back to the streaming task instead of the waiting one.
- A stream started two words from the end of its block must stop after exactly two beats with an error pulse. An off-by-one range test would either run one word into the neighbouring block or cut the stream short.
- A pending task request during host ownership must stay ungranted until the host lets go. A block that released on the same cycle, or granted while owned, would drive the bank port under the host.

// File: rtl/mba_pkg.sv
package mba_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE   = 2'b00,
    CMD_READ   = 2'b01,
    CMD_WRITE  = 2'b10,
    CMD_STREAM = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_SINGLE,
    BK_STREAM,
    BK_HOST
  } bank_state_e;

  typedef struct packed {
    logic load;
    logic step;
    logic wr;
  } bank_strobe_t;

endpackage

// File: rtl/mba_bank_ctrl.sv
module mba_bank_ctrl
  import mba_pkg::*;
#(
  parameter int TPB   = 2,
  parameter int IDX_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TPB-1:0]       req,
  input  logic [TPB*2-1:0]     cmd,
  input  logic [TPB-1:0]       addrOk,
  input  logic                 nextOk,
  input  logic                 hostReq,
  output bank_strobe_t         strobe,
  output logic [IDX_W-1:0]     selIdx,
  output logic [TPB-1:0]       gnt,
  output logic                 hostOwn,
  output logic [TPB-1:0]       err
);

  bank_state_e      state, nState;
  logic [IDX_W-1:0] owner, nOwner, ptr, nPtr, winIdx;
  logic [TPB-1:0]   elig, bad, badPrev, nGnt, ovMask;
  logic             anyElig, overrunHit;
  cmd_e             winCmd;

  always_comb begin
    for (int i = 0; i < TPB; i++) begin
      elig[i] = req[i] && (cmd[i*2 +: 2] != CMD_IDLE) && addrOk[i];
      bad[i]  = req[i] && (cmd[i*2 +: 2] != CMD_IDLE) && !addrOk[i];
    end
  end

  // rotate priority to start just past the last completed owner
  always_comb begin
    int cand;
    anyElig = 1'b0;
    winIdx  = '0;
    for (int off = 1; off <= TPB; off++) begin
      cand = (int'(ptr) + off) % TPB;
      if (!anyElig && elig[IDX_W'(cand)]) begin
        anyElig = 1'b1;
        winIdx  = IDX_W'(cand);
      end
    end
  end

  assign winCmd = cmd_e'(cmd[winIdx*2 +: 2]);

  always_comb begin
    nState     = state;
    nOwner     = owner;
    nPtr       = ptr;
    nGnt       = '0;
    strobe     = '0;
    overrunHit = 1'b0;
    case (state)
      BK_IDLE: begin
        if (hostReq) begin
          nState = BK_HOST;
        end else if (anyElig) begin
          nOwner       = winIdx;
          nGnt[winIdx] = 1'b1;
          strobe.load  = 1'b1;
          strobe.wr    = (winCmd == CMD_WRITE);
          nState       = (winCmd == CMD_STREAM) ? BK_STREAM : BK_SINGLE;
        end
      end
      BK_SINGLE: begin
        nState = BK_IDLE;
        nPtr   = owner;
      end
      BK_STREAM: begin
        if (req[owner] && nextOk) begin
          nGnt[owner] = 1'b1;
          strobe.step = 1'b1;
        end else begin
          nState     = BK_IDLE;
          nPtr       = owner;
          overrunHit = req[owner];
        end
      end
      BK_HOST: begin
        if (!hostReq) nState = BK_IDLE;
      end
      default: nState = BK_IDLE;
    endcase
  end

  assign selIdx = (state == BK_IDLE) ? winIdx : owner;

  always_comb begin
    ovMask        = '0;
    ovMask[owner] = overrunHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= BK_IDLE;
      owner   <= '0;
      ptr     <= IDX_W'(TPB - 1);
      gnt     <= '0;
      hostOwn <= 1'b0;
      err     <= '0;
      badPrev <= '0;
    end else begin
      state   <= nState;
      owner   <= nOwner;
      ptr     <= nPtr;
      gnt     <= nGnt;
      hostOwn <= (nState == BK_HOST);
      err     <= (bad & ~badPrev) | ovMask;
      badPrev <= bad;
    end
  end

endmodule

// File: rtl/mba_bank_dp.sv
module mba_bank_dp
  import mba_pkg::*;
#(
  parameter int TPB         = 2,
  parameter int IDX_W       = 1,
  parameter int LADDR_W     = 8,
  parameter int DATA_W      = 16,
  parameter int GADDR_W     = 9,
  parameter int BLOCK_WORDS = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TPB*LADDR_W-1:0] addr,
  input  logic [TPB*DATA_W-1:0]  wdata,
  input  bank_strobe_t           strobe,
  input  logic [IDX_W-1:0]       selIdx,
  input  logic [DATA_W-1:0]      memRdata,
  output logic [TPB-1:0]         addrOk,
  output logic                   nextOk,
  output logic                   memEn,
  output logic                   memWe,
  output logic [GADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]      memWdata,
  output logic [TPB-1:0]         rvalid,
  output logic [DATA_W-1:0]      rdata
);

  localparam logic [LADDR_W:0]   BLOCK_LIM = (LADDR_W+1)'(BLOCK_WORDS);
  localparam logic [GADDR_W-1:0] BLOCK_G   = GADDR_W'(BLOCK_WORDS);

  logic [LADDR_W-1:0] curLocal, selAddr;
  logic [IDX_W-1:0]   curSlot, rdSlot1;
  logic               rdPend1;
  logic [GADDR_W-1:0] relocAddr;

  for (genvar i = 0; i < TPB; i++) begin : g_range
    assign addrOk[i] = {1'b0, addr[i*LADDR_W +: LADDR_W]} < BLOCK_LIM;
  end

  assign selAddr   = addr[selIdx*LADDR_W +: LADDR_W];
  assign relocAddr = GADDR_W'(selIdx) * BLOCK_G + GADDR_W'(selAddr);
  assign nextOk    = ({1'b0, curLocal} + 1'b1) < BLOCK_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curLocal <= '0;
      curSlot  <= '0;
      memEn    <= 1'b0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memWdata <= '0;
    end else if (strobe.load) begin
      curLocal <= selAddr;
      curSlot  <= selIdx;
      memEn    <= 1'b1;
      memWe    <= strobe.wr;
      memAddr  <= relocAddr;
      memWdata <= wdata[selIdx*DATA_W +: DATA_W];
    end else if (strobe.step) begin
      curLocal <= curLocal + 1'b1;
      memEn    <= 1'b1;
      memWe    <= 1'b0;
      memAddr  <= memAddr + 1'b1;
    end else begin
      memEn <= 1'b0;
      memWe <= 1'b0;
    end
  end

  // read return: memory answers one cycle after the access, captured here one more
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPend1 <= 1'b0;
      rdSlot1 <= '0;
      rvalid  <= '0;
      rdata   <= '0;
    end else begin
      rdPend1 <= memEn && !memWe;
      rdSlot1 <= curSlot;
      rvalid  <= '0;
      if (rdPend1) begin
        rvalid[rdSlot1] <= 1'b1;
        rdata           <= memRdata;
      end
    end
  end

endmodule

// File: rtl/mba_mem_arbiter.sv
module mba_mem_arbiter
  import mba_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int TPB         = 2,
  parameter int LADDR_W     = 8,
  parameter int DATA_W      = 16,
  parameter int BLOCK_WORDS = 200,
  localparam int NUM_TASKS  = NUM_BANKS * TPB,
  localparam int GADDR_W    = $clog2(TPB * BLOCK_WORDS),
  localparam int IDX_W      = (TPB > 1) ? $clog2(TPB) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_TASKS-1:0]         taskReq,
  input  logic [NUM_TASKS*2-1:0]       taskCmd,
  input  logic [NUM_TASKS*LADDR_W-1:0] taskAddr,
  input  logic [NUM_TASKS*DATA_W-1:0]  taskWdata,
  output logic [NUM_TASKS-1:0]         taskGnt,
  output logic [NUM_TASKS-1:0]         taskRvalid,
  output logic [NUM_TASKS*DATA_W-1:0]  taskRdata,
  output logic [NUM_TASKS-1:0]         taskErr,
  input  logic [NUM_BANKS-1:0]         hostReq,
  output logic [NUM_BANKS-1:0]         hostOwn,
  output logic [NUM_BANKS-1:0]         memEn,
  output logic [NUM_BANKS-1:0]         memWe,
  output logic [NUM_BANKS*GADDR_W-1:0] memAddr,
  output logic [NUM_BANKS*DATA_W-1:0]  memWdata,
  input  logic [NUM_BANKS*DATA_W-1:0]  memRdata
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_strobe_t     strobe;
    logic [IDX_W-1:0] selIdx;
    logic [TPB-1:0]   addrOk;
    logic             nextOk;
    logic [DATA_W-1:0] bankRdata;

    mba_bank_ctrl #(.TPB(TPB), .IDX_W(IDX_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (taskReq[b*TPB +: TPB]),
      .cmd     (taskCmd[b*TPB*2 +: TPB*2]),
      .addrOk  (addrOk),
      .nextOk  (nextOk),
      .hostReq (hostReq[b]),
      .strobe  (strobe),
      .selIdx  (selIdx),
      .gnt     (taskGnt[b*TPB +: TPB]),
      .hostOwn (hostOwn[b]),
      .err     (taskErr[b*TPB +: TPB])
    );

    mba_bank_dp #(
      .TPB(TPB), .IDX_W(IDX_W), .LADDR_W(LADDR_W), .DATA_W(DATA_W),
      .GADDR_W(GADDR_W), .BLOCK_WORDS(BLOCK_WORDS)
    ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (taskAddr[b*TPB*LADDR_W +: TPB*LADDR_W]),
      .wdata    (taskWdata[b*TPB*DATA_W +: TPB*DATA_W]),
      .strobe   (strobe),
      .selIdx   (selIdx),
      .memRdata (memRdata[b*DATA_W +: DATA_W]),
      .addrOk   (addrOk),
      .nextOk   (nextOk),
      .memEn    (memEn[b]),
      .memWe    (memWe[b]),
      .memAddr  (memAddr[b*GADDR_W +: GADDR_W]),
      .memWdata (memWdata[b*DATA_W +: DATA_W]),
      .rvalid   (taskRvalid[b*TPB +: TPB]),
      .rdata    (bankRdata)
    );

    for (genvar s = 0; s < TPB; s++) begin : g_fan
      assign taskRdata[(b*TPB+s)*DATA_W +: DATA_W] = bankRdata;
    end
  end

endmodule

// File: rtl/mba_checker.sv
module mba_checker #(
  parameter int NUM_BANKS   = 4,
  parameter int TPB         = 2,
  parameter int GADDR_W     = 9,
  parameter int BLOCK_WORDS = 200
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_BANKS*TPB-1:0]     taskGnt,
  input logic [NUM_BANKS*TPB-1:0]     taskErr,
  input logic [NUM_BANKS*TPB-1:0]     taskRvalid,
  input logic [NUM_BANKS-1:0]         hostOwn,
  input logic [NUM_BANKS-1:0]         memEn,
  input logic [NUM_BANKS-1:0]         memWe,
  input logic [NUM_BANKS*GADDR_W-1:0] memAddr
);

  localparam logic [GADDR_W-1:0] BANK_LIM = GADDR_W'(TPB * BLOCK_WORDS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(taskGnt[b*TPB +: TPB]));

    assert_host_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hostOwn[b] |-> (!memEn[b] && (taskGnt[b*TPB +: TPB] == '0)));

    assert_read_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (memEn[b] && !memWe[b]) |-> ##2 ($countones(taskRvalid[b*TPB +: TPB]) == 1));

    assert_bank_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      memEn[b] |-> (memAddr[b*GADDR_W +: GADDR_W] < BANK_LIM));
  end

  for (genvar t = 0; t < NUM_BANKS*TPB; t++) begin : g_task_chk
    assert_err_no_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      taskErr[t] |-> !taskGnt[t]);
  end

endmodule

bind mba_mem_arbiter mba_checker #(
  .NUM_BANKS(NUM_BANKS), .TPB(TPB), .GADDR_W(GADDR_W), .BLOCK_WORDS(BLOCK_WORDS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .taskGnt    (taskGnt),
  .taskErr    (taskErr),
  .taskRvalid (taskRvalid),
  .hostOwn    (hostOwn),
  .memEn      (memEn),
  .memWe      (memWe),
  .memAddr    (memAddr)
);

// File: tb/mba_mem_arbiter_tb.sv
`timescale 1ns/1ps
module mba_mem_arbiter_tb;

  localparam int NB  = 4;
  localparam int TPB = 2;
  localparam int NT  = NB * TPB;
  localparam int LAW = 8;
  localparam int DW  = 16;
  localparam int GAW = 9;
  localparam int BLK = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0]     taskReq = '0;
  logic [NT*2-1:0]   taskCmd = '0;
  logic [NT*LAW-1:0] taskAddr = '0;
  logic [NT*DW-1:0]  taskWdata = '0;
  logic [NT-1:0]     taskGnt, taskRvalid, taskErr;
  logic [NT*DW-1:0]  taskRdata;
  logic [NB-1:0]     hostReq = '0;
  logic [NB-1:0]     hostOwn, memEn, memWe;
  logic [NB*GAW-1:0] memAddr;
  logic [NB*DW-1:0]  memWdata;
  logic [NB*DW-1:0]  memRdata;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  mba_mem_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .taskReq(taskReq), .taskCmd(taskCmd),
    .taskAddr(taskAddr), .taskWdata(taskWdata), .taskGnt(taskGnt),
    .taskRvalid(taskRvalid), .taskRdata(taskRdata), .taskErr(taskErr),
    .hostReq(hostReq), .hostOwn(hostOwn), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // behavioural banks: one-cycle synchronous read, preset pattern bank*1000+word
  logic [DW-1:0] memArr [NB][512];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < 512; i++) memArr[b][i] <= DW'(b*1000 + i);
      memRdata <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (memEn[b]) begin
          if (memWe[b]) memArr[b][memAddr[b*GAW +: GAW]] <= memWdata[b*DW +: DW];
          else          memRdata[b*DW +: DW] <= memArr[b][memAddr[b*GAW +: GAW]];
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setTask(int t, bit rq, logic [1:0] cm, int ad, int wd);
    taskReq[t]             = rq;
    taskCmd[t*2 +: 2]      = cm;
    taskAddr[t*LAW +: LAW] = LAW'(ad);
    taskWdata[t*DW +: DW]  = DW'(wd);
  endtask

  function automatic int bankAddr(int b);
    return int'(memAddr[b*GAW +: GAW]);
  endfunction

  function automatic int rdOf(int t);
    return int'(taskRdata[t*DW +: DW]);
  endfunction

  task automatic drain();
    for (int i = 0; i < 4; i++) tick();
  endtask

  // R9
  task automatic testReset();
    check("R9 gnt", int'(taskGnt), 0);
    check("R9 memEn", int'(memEn), 0);
    check("R9 hostOwn", int'(hostOwn), 0);
    check("R9 rvalid", int'(taskRvalid), 0);
    check("R9 err", int'(taskErr), 0);
  endtask

  // R1 R2 single read on task 3
  task automatic testRead();
    setTask(3, 1, 2'b01, 5, 0);
    tick();
    check("R2 gnt task3", int'(taskGnt[3]), 1);
    check("R1 memEn bank1", int'(memEn[1]), 1);
    check("R1 reloc addr", bankAddr(1), 205);
    setTask(3, 0, 2'b00, 0, 0);
    tick();
    check("R2 rvalid not early", int'(taskRvalid[3]), 0);
    tick();
    check("R2 rvalid at +2", int'(taskRvalid[3]), 1);
    check("R2 read data", rdOf(3), 1205);
    drain();
  endtask

  // R2 write then readback on task 4
  task automatic testWrite();
    setTask(4, 1, 2'b10, 10, 16'hBEEF);
    tick();
    check("R2 write gnt", int'(taskGnt[4]), 1);
    check("R2 memWe", int'(memWe[2]), 1);
    check("R1 write addr", bankAddr(2), 10);
    setTask(4, 0, 2'b00, 0, 0);
    tick(); tick();
    check("R2 no rvalid on write", int'(taskRvalid[4]), 0);
    setTask(4, 1, 2'b01, 10, 0);
    tick();
    setTask(4, 0, 2'b00, 0, 0);
    tick(); tick();
    check("R2 readback", rdOf(4), 16'hBEEF);
    drain();
  endtask

  // R3 R10 alternation on bank 0
  task automatic testRoundRobin();
    int order[4];
    int n = 0;
    setTask(0, 1, 2'b01, 1, 0);
    setTask(1, 1, 2'b01, 2, 0);
    for (int c = 0; c < 12 && n < 4; c++) begin
      tick();
      if (taskGnt[1:0] != 2'b00) begin
        check("R10 single grant", $countones(taskGnt[1:0]), 1);
        order[n] = taskGnt[1] ? 1 : 0;
        n++;
      end
    end
    setTask(0, 0, 2'b00, 0, 0);
    setTask(1, 0, 2'b00, 0, 0);
    check("R3 grant count", n, 4);
    for (int k = 0; k < 4; k++) check("R3 alternation", order[k], k % 2);
    drain();
  endtask

  // R4 concurrent banks
  task automatic testConcurrent();
    setTask(1, 1, 2'b01, 7, 0);
    setTask(2, 1, 2'b01, 7, 0);
    setTask(5, 1, 2'b01, 7, 0);
    tick();
    check("R4 bank0 gnt", int'(taskGnt[1]), 1);
    check("R4 bank1 gnt", int'(taskGnt[2]), 1);
    check("R4 bank2 gnt", int'(taskGnt[5]), 1);
    setTask(1, 0, 2'b00, 0, 0);
    setTask(2, 0, 2'b00, 0, 0);
    setTask(5, 0, 2'b00, 0, 0);
    drain();
  endtask

  // R5 out-of-range request
  task automatic testBadAddr();
    setTask(2, 1, 2'b01, 250, 0);
    tick();
    check("R5 err pulse", int'(taskErr[2]), 1);
    check("R5 no gnt", int'(taskGnt[2]), 0);
    tick();
    check("R5 err one cycle", int'(taskErr[2]), 0);
    for (int i = 0; i < 4; i++) begin
      check("R5 no access", int'(memEn[1]), 0);
      check("R5 still no gnt", int'(taskGnt[2]), 0);
      tick();
    end
    setTask(2, 0, 2'b00, 0, 0);
    drain();
  endtask

  // R6 stream on task 6, R3 pointer after completion hands bank to task 7
  task automatic testStream();
    setTask(6, 1, 2'b11, 3, 0);
    setTask(7, 1, 2'b01, 0, 0);
    tick();
    for (int k = 0; k < 8; k++) begin
      if (k < 4) begin
        check("R6 stream gnt held", int'(taskGnt[6]), 1);
        check("R6 stream addr", bankAddr(3), 3 + k);
      end
      if (k == 4) check("R6 stream released", int'(taskGnt[6]), 0);
      if (k >= 2 && k < 6) begin
        check("R6 stream rvalid", int'(taskRvalid[6]), 1);
        check("R6 stream data", rdOf(6), 3003 + (k - 2));
      end
      if (k == 5) check("R3 waiter served after stream", int'(taskGnt[7]), 1);
      if (k == 7) begin
        check("R2 task7 rvalid", int'(taskRvalid[7]), 1);
        check("R1 task7 data", rdOf(7), 3200);
      end
      if (k == 3) setTask(6, 0, 2'b00, 0, 0);
      if (k == 5) setTask(7, 0, 2'b00, 0, 0);
      tick();
    end
    drain();
  endtask

  // R7 stream reaching block end
  task automatic testOverrun();
    setTask(5, 1, 2'b11, 198, 0);
    tick();
    check("R7 first beat addr", bankAddr(2), 398);
    tick();
    check("R7 last beat addr", bankAddr(2), 399);
    check("R7 gnt during beats", int'(taskGnt[5]), 1);
    tick();
    check("R7 err at end", int'(taskErr[5]), 1);
    check("R7 gnt dropped", int'(taskGnt[5]), 0);
    check("R7 no access past end", int'(memEn[2]), 0);
    setTask(5, 0, 2'b00, 0, 0);
    tick();
    check("R7 err one cycle", int'(taskErr[5]), 0);
    drain();
  endtask

  // R8 host ownership of bank 1
  task automatic testHost();
    hostReq[1] = 1'b1;
    setTask(3, 1, 2'b01, 9, 0);
    tick();
    check("R8 hostOwn rises", int'(hostOwn[1]), 1);
    check("R8 host beats task", int'(taskGnt[3]), 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R8 no access while owned", int'(memEn[1]), 0);
      check("R8 no gnt while owned", int'(taskGnt[3]), 0);
      check("R8 hostOwn held", int'(hostOwn[1]), 1);
    end
    hostReq[1] = 1'b0;
    tick();
    check("R8 hostOwn falls", int'(hostOwn[1]), 0);
    check("R8 no gnt on release", int'(taskGnt[3]), 0);
    tick();
    check("R8 task served after host", int'(taskGnt[3]), 1);
    check("R1 task3 addr", bankAddr(1), 209);
    setTask(3, 0, 2'b00, 0, 0);
    drain();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    tick();
    testRead();
    testWrite();
    testRoundRobin();
    testConcurrent();
    testBadAddr();
    testStream();
    testOverrun();
    testHost();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL all: watchdog expired, actual 0 expected 1");
      summary();
      $finish;
    end
  end

endmodule